// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Interrupt Status

This block sits between a host and an audio serializer. It holds two sample queues. The host fills the playback queue and the serializer drains it. The serializer fills the capture queue and the host drains it. Each queue is eight entries deep and reports its fill level (0 to 8), a full flag, an empty flag and a threshold flag measured against a 3-bit programmable level.

Four event sources feed a sticky raw status vector:

- playback overflow
- capture underflow
- playback threshold
- capture threshold

A per-source enable mask gates the raw status into one combined interrupt line. A write-one clear strobe acknowledges each source on its own. A one-cycle flush strobe empties each queue.

Each queue is controlled by a three-state machine:

- EMPTY: level 0.
- PARTIAL: level 1 to 7.
- FULL: level 8.

The transitions are:

- fill-start: EMPTY to PARTIAL, on an accepted push.
- fill-top: PARTIAL to FULL, on a push without a pop at level 7.
- drain-end: PARTIAL to EMPTY, on a pop without a push at level 1.
- drain-start: FULL to PARTIAL, on an accepted pop.
- flush: any state to EMPTY.

Top module: `audio_fifo_irq`

## Requirements
- R1: While reset is held, both levels read 0, both empty flags are 1, both full flags are 0, `irq_raw` is 0 and `irq_out` is 0.
- R2: Each queue returns samples in push order. The level counts accepted pushes minus accepted pops, up to 8. Full is asserted exactly at level 8 and empty exactly at level 0. A push into a full capture queue is dropped silently.
- R3: A playback push while the playback queue is full is dropped, leaving the level and contents unchanged. At that clock edge it sets `irq_raw` bit 4.
- R4: While the capture queue is empty, `rx_rdata` is 0. A capture pop while empty sets `irq_raw` bit 5 at that edge and leaves the level at 0.
- R5: `tx_thr` is 1 when the playback level is less than or equal to `tx_thresh`. At each clock edge where `tx_thr` is 1, `irq_raw` bit 6 is set.
- R6: `rx_thr` is 1 when the capture level is greater than `rx_thresh`. At each clock edge where `rx_thr` is 1, `irq_raw` bit 7 is set.
- R7: A one on bit n of `irq_clr` (n in 4..7) clears raw bit n at the edge. If the source's event is present at that same edge, the event wins and the bit stays set.
- R8: `irq_out` is the OR of `irq_raw & irq_en`. Raw bits 0 to 3 are always 0, so enabling only those bits never raises `irq_out`.
- R9: A flush strobe empties its queue at the next edge. A push in the flush cycle is discarded, and the next pushed sample is the next one read.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged. The pop returns the oldest sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Host writes a playback sample |
| tx_wdata | input | DATA_W | Playback sample to write |
| tx_pop | input | 1 | Serializer takes the playback head |
| tx_rdata | output | DATA_W | Playback head sample (0 when empty) |
| tx_flush | input | 1 | Flush strobe for the playback queue |
| rx_push | input | 1 | Serializer writes a capture sample |
| rx_wdata | input | DATA_W | Capture sample to write |
| rx_pop | input | 1 | Host takes the capture head |
| rx_rdata | output | DATA_W | Capture head sample (0 when empty) |
| rx_flush | input | 1 | Flush strobe for the capture queue |
| tx_thresh | input | 3 | Playback threshold level |
| rx_thresh | input | 3 | Capture threshold level |
| irq_en | input | 8 | Per-source interrupt enable (bits 4..7) |
| irq_clr | input | 8 | Write-one clear strobe (bits 4..7) |
| tx_full | output | 1 | Playback queue full |
| tx_empty | output | 1 | Playback queue empty |
| tx_level | output | 4 | Playback fill level |
| tx_thr | output | 1 | Playback threshold flag |
| rx_full | output | 1 | Capture queue full |
| rx_empty | output | 1 | Capture queue empty |
| rx_level | output | 4 | Capture fill level |
| rx_thr | output | 1 | Capture threshold flag |
| irq_raw | output | 8 | Raw sticky event status |
| irq_out | output | 1 | Combined enabled interrupt |

## Verification
Levels, full and empty flags, overflow and underflow bits, and flush results appear one edge after the cycle that caused them. Threshold flags follow the level with no extra delay. The threshold raw bits trail the level by one further edge. Head data and `irq_out` are combinational, so they settle in the same cycle as the stimulus.

The bench drives every input on the falling edge and steps one rising edge before checking registered results. It checks combinational results before that edge. It waits one extra edge before reading the threshold raw bits.

// File: rtl/afq_pkg.sv
package afq_pkg;

    typedef enum logic [1:0] {
        FQ_EMPTY,
        FQ_PARTIAL,
        FQ_FULL
    } fq_state_e;

    localparam int IRQ_W      = 8;
    localparam int SRC_TX_OVF = 4;
    localparam int SRC_RX_UDF = 5;
    localparam int SRC_TX_THR = 6;
    localparam int SRC_RX_THR = 7;
    localparam logic [IRQ_W-1:0] SRC_MASK = 8'hF0;

endpackage

// File: rtl/afq_fifo_core.sv
module afq_fifo_core
    import afq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter bit IS_TX  = 1'b1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              fault
);

    fq_state_e          state_q, state_d;
    logic [LVL_W-1:0]   level_q, level_d;
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [DATA_W-1:0]  mem [DEPTH];
    logic               push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (state_q != FQ_FULL)  && !flush;
    assign pop_ok  = pop  && (state_q != FQ_EMPTY) && !flush;

    // fault source picked by queue direction
    generate
        if (IS_TX) begin : g_tx_fault
            assign fault = push && (state_q == FQ_FULL);
        end else begin : g_rx_fault
            assign fault = pop && (state_q == FQ_EMPTY);
        end
    endgenerate

    // next-state and next-level logic
    always_comb begin
        level_d = level_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
        state_d = state_q;
        if (flush) begin
            level_d = '0;
            state_d = FQ_EMPTY;
        end else begin
            unique case (state_q)
                FQ_EMPTY: begin
                    if (push_ok) state_d = FQ_PARTIAL;                  // fill-start
                end
                FQ_PARTIAL: begin
                    if (push_ok && !pop_ok && level_q == LVL_W'(DEPTH - 1))
                        state_d = FQ_FULL;                              // fill-top
                    else if (pop_ok && !push_ok && level_q == LVL_W'(1))
                        state_d = FQ_EMPTY;                             // drain-end
                end
                FQ_FULL: begin
                    if (pop_ok) state_d = FQ_PARTIAL;                   // drain-start
                end
                default: state_d = FQ_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FQ_EMPTY;
            level_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop_ok)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // outputs
    always_comb begin
        full  = (state_q == FQ_FULL);
        empty = (state_q == FQ_EMPTY);
        level = level_q;
        rdata = (state_q == FQ_EMPTY) ? '0 : mem[rd_ptr];
    end

    p_state_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FQ_EMPTY) == (level_q == '0)) &&
        ((state_q == FQ_FULL)  == (level_q == LVL_W'(DEPTH))));

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(DEPTH));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_q == '0) && (state_q == FQ_EMPTY));

    p_level_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (level_q == $past(level_q)) ||
                   (level_q == $past(level_q) + 1'b1) ||
                   ($past(level_q) == level_q + 1'b1));

endmodule

// File: rtl/afq_irq_ctrl.sv
module afq_irq_ctrl
    import afq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] evt,
    input  logic [IRQ_W-1:0] clr,
    input  logic [IRQ_W-1:0] en,
    output logic [IRQ_W-1:0] raw,
    output logic             irq
);

    logic [IRQ_W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= ((raw_q & ~clr) | evt) & SRC_MASK;
    end

    assign raw = raw_q;
    assign irq = |(raw_q & en);

    generate
        for (genvar i = SRC_TX_OVF; i <= SRC_RX_THR; i++) begin : g_src
            p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> raw_q[i]);
            p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !evt[i]) |=> !raw_q[i]);
        end
    endgenerate

endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq
    import afq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    parameter int TH_W   = 3,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              tx_flush,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              rx_flush,
    input  logic [TH_W-1:0]   tx_thresh,
    input  logic [TH_W-1:0]   rx_thresh,
    input  logic [7:0]        irq_en,
    input  logic [7:0]        irq_clr,
    output logic              tx_full,
    output logic              tx_empty,
    output logic [LVL_W-1:0]  tx_level,
    output logic              tx_thr,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [LVL_W-1:0]  rx_level,
    output logic              rx_thr,
    output logic [7:0]        irq_raw,
    output logic              irq_out
);

    logic             tx_fault, rx_fault;
    logic [IRQ_W-1:0] evt;

    afq_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_TX(1'b1)) u_tx (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .flush(tx_flush), .rdata(tx_rdata), .level(tx_level),
        .full(tx_full), .empty(tx_empty), .fault(tx_fault)
    );

    afq_fifo_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_TX(1'b0)) u_rx (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .flush(rx_flush), .rdata(rx_rdata), .level(rx_level),
        .full(rx_full), .empty(rx_empty), .fault(rx_fault)
    );

    assign tx_thr = (tx_level <= LVL_W'(tx_thresh));
    assign rx_thr = (rx_level >  LVL_W'(rx_thresh));

    always_comb begin
        evt             = '0;
        evt[SRC_TX_OVF] = tx_fault;
        evt[SRC_RX_UDF] = rx_fault;
        evt[SRC_TX_THR] = tx_thr;
        evt[SRC_RX_THR] = rx_thr;
    end

    afq_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(irq_clr), .en(irq_en),
        .raw(irq_raw), .irq(irq_out)
    );

    p_tx_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full) |=> irq_raw[SRC_TX_OVF] && tx_full);

    p_rx_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> irq_raw[SRC_RX_UDF] && rx_empty);

    p_rx_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rx_rdata == '0));

    p_tx_thr_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_thr |=> irq_raw[SRC_TX_THR]);

    p_rx_thr_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_thr |=> irq_raw[SRC_RX_THR]);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[3:0] == 4'h0) && ((irq_raw == '0) -> !irq_out));

endmodule

// File: tb/sim_audio_fifo_irq.sv
module sim_audio_fifo_irq;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          tx_push, tx_pop, tx_flush, rx_push, rx_pop, rx_flush;
    logic [DW-1:0] tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic [2:0]    tx_thresh, rx_thresh;
    logic [7:0]    irq_en, irq_clr, irq_raw;
    logic          tx_full, tx_empty, tx_thr, rx_full, rx_empty, rx_thr, irq_out;
    logic [3:0]    tx_level, rx_level;

    audio_fifo_irq #(.DATA_W(DW), .DEPTH(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_flush(tx_flush),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_flush(rx_flush),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_en(irq_en), .irq_clr(irq_clr),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level), .tx_thr(tx_thr),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level), .rx_thr(rx_thr),
        .irq_raw(irq_raw), .irq_out(irq_out)
    );

    int total = 0;
    int bad   = 0;
    logic [DW-1:0] tx_q[$];
    logic [DW-1:0] rx_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: push into design and into the scoreboard queue
    task automatic tx_write(input logic [DW-1:0] d);
        tx_push = 1'b1; tx_wdata = d;
        if (tx_q.size() < 8) tx_q.push_back(d);
        step();
        tx_push = 1'b0;
    endtask

    task automatic rx_write(input logic [DW-1:0] d);
        rx_push = 1'b1; rx_wdata = d;
        if (rx_q.size() < 8) rx_q.push_back(d);
        step();
        rx_push = 1'b0;
    endtask

    // monitor: pop expected item and compare with the head output
    task automatic tx_read(input string tag);
        logic [DW-1:0] exp;
        exp = (tx_q.size() > 0) ? tx_q.pop_front() : '0;
        tx_pop = 1'b1;
        #1 chk(tag, tx_rdata, exp);
        step();
        tx_pop = 1'b0;
    endtask

    task automatic rx_read(input string tag);
        logic [DW-1:0] exp;
        exp = (rx_q.size() > 0) ? rx_q.pop_front() : '0;
        rx_pop = 1'b1;
        #1 chk(tag, rx_rdata, exp);
        step();
        rx_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {tx_push, tx_pop, tx_flush, rx_push, rx_pop, rx_flush} = '0;
        tx_wdata = '0; rx_wdata = '0;
        tx_thresh = 3'd2; rx_thresh = 3'd1;
        irq_en = '0; irq_clr = '0;
        step(); step(); step();
        chk("R1 tx_level", tx_level, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 rx_empty", rx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 irq_raw", irq_raw, 0);
        chk("R1 irq_out", irq_out, 0);

        rst_n = 1'b1;
        step(); step();
        chk("R5 tx thr raw at level 0", irq_raw, 8'h40);

        irq_clr = 8'h40; step(); irq_clr = '0;
        chk("R7 event wins over clear", irq_raw, 8'h40);

        tx_write(32'hA0); tx_write(32'hA1); tx_write(32'hA2);
        chk("R5 tx_level 3", tx_level, 3);
        chk("R5 tx_thr off above threshold", tx_thr, 0);
        irq_clr = 8'h40; step(); irq_clr = '0;
        chk("R7 clear works", irq_raw, 8'h00);

        for (int i = 3; i < 8; i++) tx_write(32'hA0 + i);
        chk("R2 tx_level 8", tx_level, 8);
        chk("R2 tx_full", tx_full, 1);
        chk("R2 tx_empty", tx_empty, 0);
        tx_write(32'hDEAD);
        chk("R3 level kept at overflow", tx_level, 8);
        chk("R3 overflow raw", irq_raw, 8'h10);
        chk("R8 masked irq_out", irq_out, 0);
        irq_en = 8'h10;
        #1 chk("R8 enabled irq_out", irq_out, 1);
        irq_clr = 8'h10; step(); irq_clr = '0;
        chk("R7 ovf cleared irq_out", irq_out, 0);

        for (int i = 0; i < 8; i++) tx_read("R2 tx order");
        chk("R2 tx_empty after drain", tx_empty, 1);

        tx_write(32'h11); tx_write(32'h22);
        tx_push = 1'b1; tx_wdata = 32'h33; tx_q.push_back(32'h33);
        tx_read("R10 simultaneous pop data");
        tx_push = 1'b0;
        chk("R10 level unchanged", tx_level, 2);

        tx_push = 1'b1; tx_wdata = 32'h44; tx_flush = 1'b1;
        step();
        tx_push = 1'b0; tx_flush = 1'b0; tx_q.delete();
        chk("R9 tx flushed level", tx_level, 0);
        chk("R9 tx flushed empty", tx_empty, 1);
        tx_write(32'h55);
        tx_read("R9 data after flush");

        rx_write(32'hB1);
        chk("R6 rx_thr at level 1", rx_thr, 0);
        rx_write(32'hB2);
        chk("R6 rx_thr at level 2", rx_thr, 1);
        step();
        chk("R6 rx thr raw", irq_raw[7], 1);
        rx_read("R2 rx order");
        rx_read("R2 rx order");
        rx_pop = 1'b1;
        #1 chk("R4 empty read data", rx_rdata, 0);
        step();
        rx_pop = 1'b0;
        chk("R4 underflow raw", irq_raw[5], 1);
        chk("R4 level stays 0", rx_level, 0);

        irq_en = 8'h0F;
        #1 chk("R8 reserved enables", irq_out, 0);
        irq_en = 8'h20;
        #1 chk("R8 underflow enabled", irq_out, 1);
        irq_clr = 8'h20; step(); irq_clr = '0;
        chk("R7 underflow cleared", irq_out, 0);

        rx_write(32'hC0); rx_write(32'hC1); rx_write(32'hC2);
        chk("R2 rx_level 3", rx_level, 3);
        rx_flush = 1'b1; step(); rx_flush = 1'b0; rx_q.delete();
        chk("R9 rx flushed level", rx_level, 0);
        chk("R9 rx flushed data", rx_rdata, 0);

        for (int i = 0; i < 9; i++) rx_write(32'hE0 + i);
        chk("R2 rx_full", rx_full, 1);
        chk("R2 rx_level capped", rx_level, 8);
        for (int i = 0; i < 8; i++) rx_read("R2 rx order after drop");
        chk("R2 rx_empty after drain", rx_empty, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule